// File: doc/BRIEF.md
# SDRAM Row Activation Scheduler

This block sits on the controller side of a four-bank SDRAM. It takes read and write requests, each carrying a bank, a row and a column. It turns them into ACTIVE, READ, WRITE, PRECHARGE and NOP commands on the active-low command pins. It keeps the open-row state of every bank and a separate set of timers for each bank. The minimum spacings are given as whole clock cycles: activate-to-access (T_RCD), activate-to-activate in one bank (T_RC), activate-to-activate across banks (T_RRD) and precharge-to-activate (T_RP). Each cycle count is the minimum time in nanoseconds divided by the clock period, rounded up. For example, 20 ns at an 8 ns period gives 3 cycles.

Requests are accepted through a valid/ready handshake into a one-entry look-ahead slot. A request moves from that slot into the working state machine once the access before it has gone out. The state machine has four states. ST_IDLE has no request in progress. ST_PRECHG closes a bank whose open row differs from the one requested. ST_ACTIVATE waits for T_RC, T_RP and T_RRD, then opens the row. ST_ACCESS waits for T_RCD, then issues READ or WRITE.

The transitions are as follows:
- From ST_IDLE, a waiting request is taken in. A row hit goes to ST_ACCESS, a closed bank to ST_ACTIVATE and a row miss to ST_PRECHG.
- ST_PRECHG always moves to ST_ACTIVATE.
- ST_ACTIVATE moves to ST_ACCESS once the ACTIVE has been issued.
- ST_ACCESS returns to ST_IDLE, or takes in the next request in that same cycle.

While the working request is stalled, the block may open the row of the look-ahead request early, if that request targets a different bank that is closed. This lets activation in one bank overlap an access in another.

Top module: `sdram_act_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, the pins carry NOP with address and bank at zero, and `req_ready` is high.
- R2: Pin codes for {cs_n,ras_n,cas_n,we_n} are NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100 and PRECHARGE=0010. ACTIVE drives the row on `sd_addr`. READ and WRITE drive the column on the low COL_W bits of `sd_addr`, with the upper bits zero. PRECHARGE and NOP drive `sd_addr` at zero. Every command except NOP drives its bank on `sd_ba`; NOP drives `sd_ba` at zero.
- R3: A READ or WRITE goes only to a bank whose open row equals the request row, and no fewer than T_RCD cycles after that row's ACTIVE. When nothing else is pending, it goes exactly T_RCD cycles after the ACTIVE.
- R4: Two ACTIVE commands to the same bank are at least T_RC cycles apart. A miss issued straight after a fresh activation reopens the bank exactly T_RC cycles after the previous ACTIVE.
- R5: Two ACTIVE commands are at least T_RRD cycles apart. An ACTIVE to another closed bank may go out between an ACTIVE and its access; with back-to-back requests to two closed banks, the second ACTIVE follows the first by exactly T_RRD cycles.
- R6: A request to a row other than the open one in its bank causes PRECHARGE, then ACTIVE, then the access. The ACTIVE comes no earlier than T_RP cycles after the PRECHARGE, and exactly T_RP after it when T_RC has already elapsed. An ACTIVE never targets a bank that is open.
- R7: A request that hits the open row issues no ACTIVE or PRECHARGE. When T_RCD has passed, the request is accepted on edge a and its access appears on edge a+2.
- R8: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Accesses leave in acceptance order, at most one command is issued per cycle, and NOP is issued on every cycle that has no legal command.
- R9: `sd_cke` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Look-ahead slot free; request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W (2) | Target bank |
| req_row | input | ROW_W (12) | Target row |
| req_col | input | COL_W (10) | Target column |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W (12) | Row or column address |
| sd_ba | output | BA_W (2) | Bank address |

## Verification
The working request's access can become legal in the same cycle as an early ACTIVE for the look-ahead request, and only one command may go out. The bench provokes this by opening bank 2 and then timing a request to bank 3 so that it lands in the look-ahead slot on the edge where bank 2's T_RCD expires. It judges the outcome by cycle stamps on the pins. The READ must appear exactly T_RCD after bank 2's ACTIVE, and bank 3's ACTIVE exactly one cycle later, so the access is shown to win the tie.

// File: rtl/sdsch_pkg.sv
package sdsch_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } sdcmd_e;

    // {cs_n, ras_n, cas_n, we_n}
    function automatic logic [3:0] pin_code(input sdcmd_e c);
        logic [3:0] code;
        unique case (c)
            CMD_NOP: code = 4'b0111;
            CMD_ACT: code = 4'b0011;
            CMD_RD:  code = 4'b0101;
            CMD_WR:  code = 4'b0100;
            CMD_PRE: code = 4'b0010;
            default: code = 4'b0111;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/sdsch_gap_timer.sv
module sdsch_gap_timer #(
    parameter int unsigned CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYCLES - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R3: a fresh start blocks the guarded command on the following cycle
    a_r3_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (CYCLES > 1)) |=> !done);

    // R4: once elapsed, a window stays open until restarted
    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/sdsch_bank_unit.sv
module sdsch_bank_unit #(
    parameter int unsigned ROW_W = 12,
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_RC  = 9,
    parameter int unsigned T_RP  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             access_ok,
    output logic             activate_ok
);
    logic rc_done;
    logic rp_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (act_fire) begin
            is_open  <= 1'b1;
            open_row <= row_in;
        end else if (pre_fire) begin
            is_open  <= 1'b0;
        end
    end

    sdsch_gap_timer #(.CYCLES(T_RCD)) i_rcd (
        .clk(clk), .rst_n(rst_n), .start(act_fire), .done(access_ok)
    );
    sdsch_gap_timer #(.CYCLES(T_RC)) i_rc (
        .clk(clk), .rst_n(rst_n), .start(act_fire), .done(rc_done)
    );
    sdsch_gap_timer #(.CYCLES(T_RP)) i_rp (
        .clk(clk), .rst_n(rst_n), .start(pre_fire), .done(rp_done)
    );

    assign activate_ok = rc_done && rp_done;

    // R8: one command per cycle reaches any bank
    always_comb begin
        if (rst_n) begin
            a_r8_one_cmd: assert (!(act_fire && pre_fire));
        end
    end

    // R6: a precharge closes the bank
    a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        pre_fire |=> !is_open);

    // R3: an activation records its row
    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |=> (is_open && open_row == $past(row_in)));

    // R4: the same bank cannot be reactivated on the next cycle
    a_r4_rc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (act_fire && (T_RC > 1)) |=> !activate_ok);

endmodule

// File: rtl/sdsch_cmd_drive.sv
module sdsch_cmd_drive
    import sdsch_pkg::*;
#(
    parameter int unsigned ROW_W = 12,
    parameter int unsigned COL_W = 10,
    parameter int unsigned BA_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sdcmd_e           cmd,
    input  logic [BA_W-1:0]  bank,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr,
    output logic [BA_W-1:0]  ba
);
    logic [ROW_W-1:0] addr_d;
    logic [BA_W-1:0]  ba_d;

    always_comb begin
        unique case (cmd)
            CMD_ACT:        begin addr_d = row;         ba_d = bank; end
            CMD_RD, CMD_WR: begin addr_d = ROW_W'(col); ba_d = bank; end
            CMD_PRE:        begin addr_d = '0;          ba_d = bank; end
            default:        begin addr_d = '0;          ba_d = '0;   end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_n, ras_n, cas_n, we_n} <= pin_code(CMD_NOP);
            addr <= '0;
            ba   <= '0;
        end else begin
            {cs_n, ras_n, cas_n, we_n} <= pin_code(cmd);
            addr <= addr_d;
            ba   <= ba_d;
        end
    end

    // R2: a precharge leaves the address bus at zero
    a_r2_pre_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |=> (addr == '0 && {cs_n, ras_n, cas_n, we_n} == 4'b0010));

endmodule

// File: rtl/sdram_act_sched.sv
module sdram_act_sched
    import sdsch_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned ROW_W     = 12,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned T_RCD     = 3,
    parameter int unsigned T_RC      = 9,
    parameter int unsigned T_RRD     = 2,
    parameter int unsigned T_RP      = 3,
    localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [ROW_W-1:0] sd_addr,
    output logic [BA_W-1:0]  sd_ba
);
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRECHG,
        ST_ACTIVATE,
        ST_ACCESS
    } state_e;

    state_e state, nstate;

    // look-ahead slot
    logic             nxt_valid;
    logic             nxt_write;
    logic [BA_W-1:0]  nxt_bank;
    logic [ROW_W-1:0] nxt_row;
    logic [COL_W-1:0] nxt_col;

    // working request
    logic             cur_write;
    logic [BA_W-1:0]  cur_bank;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;

    // bank tracker view
    logic             bank_open   [NUM_BANKS];
    logic [ROW_W-1:0] bank_row    [NUM_BANKS];
    logic             bank_acc_ok [NUM_BANKS];
    logic             bank_act_ok [NUM_BANKS];
    logic [NUM_BANKS-1:0] act_vec;
    logic [NUM_BANKS-1:0] pre_vec;
    logic             rrd_done;

    // command decision
    sdcmd_e           cmd;
    logic [BA_W-1:0]  cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic             retire;
    logic             take;
    logic             nxt_open;
    logic             nxt_hit;
    logic             early_ok;

    assign sd_cke    = 1'b1;
    assign req_ready = !nxt_valid;

    assign nxt_open = bank_open[nxt_bank];
    assign nxt_hit  = nxt_open && (bank_row[nxt_bank] == nxt_row);
    assign early_ok = nxt_valid && (nxt_bank != cur_bank) && !nxt_open &&
                      bank_act_ok[nxt_bank] && rrd_done;

    // state register and request slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            nxt_valid <= 1'b0;
            nxt_write <= 1'b0;
            nxt_bank  <= '0;
            nxt_row   <= '0;
            nxt_col   <= '0;
            cur_write <= 1'b0;
            cur_bank  <= '0;
            cur_row   <= '0;
            cur_col   <= '0;
        end else begin
            state <= nstate;
            if (take) begin
                nxt_valid <= 1'b0;
                cur_write <= nxt_write;
                cur_bank  <= nxt_bank;
                cur_row   <= nxt_row;
                cur_col   <= nxt_col;
            end else if (req_valid && req_ready) begin
                nxt_valid <= 1'b1;
                nxt_write <= req_write;
                nxt_bank  <= req_bank;
                nxt_row   <= req_row;
                nxt_col   <= req_col;
            end
        end
    end

    // next state and command
    always_comb begin
        nstate   = state;
        cmd      = CMD_NOP;
        cmd_bank = cur_bank;
        cmd_row  = cur_row;
        retire   = 1'b0;
        unique case (state)
            ST_IDLE: nstate = ST_IDLE;
            ST_PRECHG: begin
                cmd    = CMD_PRE;
                nstate = ST_ACTIVATE;
            end
            ST_ACTIVATE: begin
                if (bank_act_ok[cur_bank] && rrd_done) begin
                    cmd    = CMD_ACT;
                    nstate = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (bank_acc_ok[cur_bank]) begin
                    cmd    = cur_write ? CMD_WR : CMD_RD;
                    retire = 1'b1;
                    nstate = ST_IDLE;
                end
            end
            default: nstate = ST_IDLE;
        endcase
        if ((cmd == CMD_NOP) && (state != ST_IDLE) && early_ok) begin
            cmd      = CMD_ACT;
            cmd_bank = nxt_bank;
            cmd_row  = nxt_row;
        end
        take = nxt_valid && ((state == ST_IDLE) || retire);
        if (take) begin
            nstate = nxt_hit  ? ST_ACCESS :
                     nxt_open ? ST_PRECHG : ST_ACTIVATE;
        end
    end

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign act_vec[b] = (cmd == CMD_ACT) && (cmd_bank == BA_W'(b));
            assign pre_vec[b] = (cmd == CMD_PRE) && (cmd_bank == BA_W'(b));
            sdsch_bank_unit #(
                .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP)
            ) i_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .act_fire   (act_vec[b]),
                .pre_fire   (pre_vec[b]),
                .row_in     (cmd_row),
                .is_open    (bank_open[b]),
                .open_row   (bank_row[b]),
                .access_ok  (bank_acc_ok[b]),
                .activate_ok(bank_act_ok[b])
            );
        end
    endgenerate

    sdsch_gap_timer #(.CYCLES(T_RRD)) i_rrd (
        .clk(clk), .rst_n(rst_n), .start(cmd == CMD_ACT), .done(rrd_done)
    );

    sdsch_cmd_drive #(.ROW_W(ROW_W), .COL_W(COL_W), .BA_W(BA_W)) i_drive (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .bank (cmd_bank),
        .row  (cmd_row),
        .col  (cur_col),
        .cs_n (sd_cs_n),
        .ras_n(sd_ras_n),
        .cas_n(sd_cas_n),
        .we_n (sd_we_n),
        .addr (sd_addr),
        .ba   (sd_ba)
    );

    // R3: accesses only reach the open, matching row
    a_r3_access_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |->
            (bank_open[cur_bank] && bank_row[cur_bank] == cur_row));

    // R6: activation never targets an open bank
    a_r6_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> !bank_open[cmd_bank]);

    // R6: the precharge state is reached only on a row miss
    a_r6_pre_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRECHG) |->
            (bank_open[cur_bank] && bank_row[cur_bank] != cur_row));

    // R5: no two activations on adjacent cycles
    a_r5_rrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_ACT) && (T_RRD > 1)) |=> (cmd != CMD_ACT));

    // R8: a held look-ahead request stays unchanged
    a_r8_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_valid && !take) |=> (nxt_valid && $stable(nxt_row) && $stable(nxt_bank)));

endmodule

// File: tb/test_sdram_act_sched.sv
`timescale 1ns/1ps
module test_sdram_act_sched;
    localparam int T_RCD = 3;
    localparam int T_RC  = 9;
    localparam int T_RRD = 2;
    localparam int T_RP  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [11:0] sd_addr;
    logic [1:0]  sd_ba;

    sdram_act_sched #(
        .T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RP(T_RP)
    ) i_sdram_act_sched (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    always #2.5ns clk = ~clk;

    typedef struct packed {
        logic        w;
        logic [1:0]  bank;
        logic [11:0] row;
        logic [9:0]  col;
    } exp_t;

    exp_t exp_q[$];
    int nchecks = 0;
    int nerr = 0;
    int cyc = 0;
    bit finished = 0;

    int last_act [4];
    int prev_act [4];
    int last_pre [4];
    int last_acc [4];
    int last_any_act = -1000;
    bit mon_open [4];
    int mon_row  [4];
    int act_cnt = 0, pre_cnt = 0, acc_cnt = 0;
    bit model_open [4];
    int model_row  [4];
    int exp_act = 0, exp_pre = 0;
    int send_cyc = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input int actual, input int expected);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, actual, expected);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: decode pins, score accesses
    logic [3:0] mcode;
    int mb;
    exp_t e;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            mcode = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            mb = int'(sd_ba);
            if (!sd_cke) check(0, "R9", "cke low", 0, 1);
            case (mcode)
                4'b0111: begin
                    if (sd_addr != 0 || sd_ba != 0)
                        check(0, "R2", "NOP bus not idle", int'({sd_ba, sd_addr}), 0);
                end
                4'b0011: begin
                    check(!mon_open[mb], "R6", "ACTIVE to open bank", int'(mon_open[mb]), 0);
                    check(cyc - last_act[mb] >= T_RC, "R4", "same-bank ACT gap",
                          cyc - last_act[mb], T_RC);
                    check(cyc - last_any_act >= T_RRD, "R5", "ACT-ACT gap",
                          cyc - last_any_act, T_RRD);
                    check(cyc - last_pre[mb] >= T_RP, "R6", "PRE-ACT gap",
                          cyc - last_pre[mb], T_RP);
                    prev_act[mb] = last_act[mb];
                    last_act[mb] = cyc;
                    last_any_act = cyc;
                    mon_open[mb] = 1;
                    mon_row[mb]  = int'(sd_addr);
                    act_cnt++;
                end
                4'b0010: begin
                    check(mon_open[mb], "R6", "PRE to closed bank", int'(mon_open[mb]), 1);
                    check(sd_addr == 0, "R2", "PRE address", int'(sd_addr), 0);
                    last_pre[mb] = cyc;
                    mon_open[mb] = 0;
                    pre_cnt++;
                end
                4'b0101, 4'b0100: begin
                    if (exp_q.size() == 0) begin
                        check(0, "R8", "unexpected access", mb, -1);
                    end else begin
                        e = exp_q.pop_front();
                        check((mcode == 4'b0100) == e.w, "R2", "read/write code",
                              int'(mcode), e.w ? 4 : 5);
                        check(mb == int'(e.bank), "R8", "access bank order", mb, int'(e.bank));
                        check(sd_addr == 12'(e.col), "R2", "column on address",
                              int'(sd_addr), int'(e.col));
                        check(mon_open[mb] && mon_row[mb] == int'(e.row), "R3",
                              "access row open", mon_row[mb], int'(e.row));
                        check(cyc - last_act[mb] >= T_RCD, "R3", "ACT-access gap",
                              cyc - last_act[mb], T_RCD);
                    end
                    last_acc[mb] = cyc;
                    acc_cnt++;
                end
                default: check(0, "R2", "illegal pin code", int'(mcode), 7);
            endcase
        end
    end

    task automatic send(input bit w, input int bank, input int row, input int col);
        exp_t it;
        it.w = w; it.bank = 2'(bank); it.row = 12'(row); it.col = 10'(col);
        exp_q.push_back(it);
        if (!model_open[bank]) begin
            exp_act++;
        end else if (model_row[bank] != row) begin
            exp_pre++;
            exp_act++;
        end
        model_open[bank] = 1;
        model_row[bank]  = row;
        req_valid = 1'b1;
        req_write = w;
        req_bank  = 2'(bank);
        req_row   = 12'(row);
        req_col   = 10'(col);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        send_cyc  = cyc;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #750us;
        if (!finished) begin
            finished = 1;
            nerr++;
            nchecks++;
            $display("FAIL watchdog R8: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            last_act[i] = -1000; prev_act[i] = -1000;
            last_pre[i] = -1000; last_acc[i] = -1000;
            mon_open[i] = 0; mon_row[i] = 0;
            model_open[i] = 0; model_row[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "NOP in reset",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        check(sd_addr == 0 && sd_ba == 0, "R1", "bus idle in reset", int'(sd_addr), 0);
        check(req_ready, "R1", "ready in reset", int'(req_ready), 1);
        check(sd_cke, "R9", "cke high", int'(sd_cke), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && req_ready, "R1",
              "NOP and ready after reset", int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);

        // R5 overlap: back-to-back requests to two closed banks
        send(0, 0, 17, 5);
        send(0, 1, 33, 6);
        idle(30);
        check(last_act[1] - last_act[0] == T_RRD, "R5", "second ACT at T_RRD",
              last_act[1] - last_act[0], T_RRD);
        check(last_acc[0] > last_act[1], "R5", "ACT overlaps access",
              last_acc[0] - last_act[1], 1);
        check(last_acc[0] - last_act[0] == T_RCD, "R3", "access exactly T_RCD",
              last_acc[0] - last_act[0], T_RCD);
        check(last_acc[1] - last_act[1] == T_RCD, "R3", "second access T_RCD",
              last_acc[1] - last_act[1], T_RCD);

        // tie: bank 2 access ready while bank 3 request arrives
        send(1, 2, 5, 100);
        idle(3);
        send(0, 3, 44, 101);
        idle(30);
        check(last_acc[2] - last_act[2] == T_RCD, "R3", "access wins tie",
              last_acc[2] - last_act[2], T_RCD);
        check(last_act[3] - last_act[2] == T_RCD + 1, "R8", "ACT one cycle after access",
              last_act[3] - last_act[2], T_RCD + 1);

        // R7: row hit
        begin
            int a0, p0;
            a0 = act_cnt; p0 = pre_cnt;
            send(1, 1, 33, 77);
            idle(20);
            check(act_cnt == a0 && pre_cnt == p0, "R7", "hit issues no ACT/PRE",
                  act_cnt - a0 + pre_cnt - p0, 0);
            check(last_acc[1] - send_cyc == 2, "R7", "hit access latency",
                  last_acc[1] - send_cyc, 2);
        end

        // R6: row miss after quiet time
        send(0, 0, 9, 3);
        idle(30);
        check(last_pre[0] - send_cyc == 2, "R6", "PRE first", last_pre[0] - send_cyc, 2);
        check(last_act[0] - last_pre[0] == T_RP, "R6", "ACT exactly T_RP after PRE",
              last_act[0] - last_pre[0], T_RP);
        check(last_acc[0] - last_act[0] == T_RCD, "R6", "access after reopen",
              last_acc[0] - last_act[0], T_RCD);

        // R4: two misses back-to-back in one bank
        send(0, 2, 7, 11);
        send(1, 2, 8, 12);
        idle(40);
        check(last_act[2] - prev_act[2] == T_RC, "R4", "reopen exactly T_RC",
              last_act[2] - prev_act[2], T_RC);

        // mixed traffic
        for (int n = 0; n < 80; n++) begin
            send(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 1023));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 6));
        end
        while (exp_q.size() != 0) @(negedge clk);
        idle(20);

        check(exp_q.size() == 0, "R8", "all accesses issued", exp_q.size(), 0);
        check(act_cnt == exp_act, "R6", "ACTIVE count", act_cnt, exp_act);
        check(pre_cnt == exp_pre, "R7", "PRECHARGE count", pre_cnt, exp_pre);
        for (int k = 0; k < 4; k++) begin
            check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R8", "NOP when idle",
                  int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
            @(negedge clk);
        end
        check(sd_cke, "R9", "cke high at end", int'(sd_cke), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule